// File: doc/BRIEF.md
# Add/Subtract Unit with Legacy Flags

This block is an integer add/subtract unit with a registered result and a registered 32-bit flags word. Each clock cycle it takes two operands and an operation code, adds or subtracts at either 32-bit or 64-bit width, and updates the result register and, when asked, the flags word. The flags word always carries the four standard condition bits: negative, zero, carry and overflow.

An optional legacy mode adds two auxiliary flags taken from older eight-bit processor families. These are an even-parity flag over the low byte of the result and a nibble-carry (adjust) flag that shows a carry or borrow across bit 3. Both are computed alongside the main flags in the same cycle, so the mode adds no latency. Binary translators use it to keep both flags exact without extra instructions.

A compare is a subtraction that changes only the flags. Add and subtract without the flag-setting qualifier change only the result.

Top module: `addsub_flags_unit`

## Requirements
- R1: Operation codes on `op_sel` are 00 add, 01 subtract, 10 compare, and 11 also add. An add stores (a + b) modulo 2^width into `result` one clock edge after the inputs are presented. With `wide`=0 the width is 32 and `result[63:32]` is zero.
- R2: A subtract stores (a - b) modulo 2^width into `result`, under the same width and timing rules as R1.
- R3: A compare leaves `result` unchanged. When `set_flags` is 1 it updates the flags exactly as a subtract of the same operands would.
- R4: Flags bit 31 (N) is the sign bit of the result at the selected width. Bit 30 (Z) is 1 when the result at that width is zero.
- R5: Flags bit 29 (C) is the carry out of an add. For subtract and compare it is 1 when a >= b unsigned at the selected width, meaning no borrow.
- R6: Flags bit 28 (V) is 1 when the signed result at the selected width overflows.
- R7: With `legacy_en`=1, flags bit 26 is 1 when bits 7:0 of the result contain an even number of ones, for either width.
- R8: With `legacy_en`=1, flags bit 27 is 1 when an add carries out of bit 3, or when a subtract or compare borrows out of bit 3.
- R9: With `legacy_en`=0, flags bits 27:26 keep their previous values. N, Z, C and V still update as R4 to R6 describe.
- R10: With `set_flags`=0, the whole flags word keeps its previous value for any operation.
- R11: After reset, `result` and `flags` are zero. Flags bits 25:0 stay zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| op_sel | input | 2 | Operation code (00 add, 01 sub, 10 compare, 11 add) |
| set_flags | input | 1 | Flag-setting qualifier |
| wide | input | 1 | 1 selects 64-bit, 0 selects 32-bit |
| legacy_en | input | 1 | Enables the parity and adjust flags |
| result | output | 64 | Registered result |
| flags | output | 32 | Registered flags word |

## Verification
On every cycle, the assertions check the hold rules. The flags stay put without the qualifier, and the legacy bits stay put with the mode off. A compare keeps the result, and narrow results keep their upper half at zero. They also check that Z agrees with the stored result. Only the bench's scenarios can show that the values are arithmetically correct: the carry and overflow at the exact 32-bit and 64-bit boundaries, the nibble borrow, and parity in the low byte. These come from directed corner cases and seeded random operations, checked against bench functions that use range tests and nibble comparisons instead of the design's adder formulation.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int FLAG_W  = 32;
  localparam int N_BIT   = 31;
  localparam int Z_BIT   = 30;
  localparam int C_BIT   = 29;
  localparam int V_BIT   = 28;
  localparam int AF_BIT  = 27;
  localparam int PF_BIT  = 26;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_ADD2 = 2'b11
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } base_flags_t;

  function automatic logic is_subtract(op_e op);
    return (op == OP_SUB) || (op == OP_CMP);
  endfunction

  function automatic logic writes_result(op_e op);
    return op != OP_CMP;
  endfunction

  function automatic logic even_parity8(logic [7:0] v);
    return ~(^v);
  endfunction

  function automatic logic nibble_cross(logic [7:0] a, logic [7:0] b, logic [7:0] r);
    logic [7:0] x;
    x = a ^ b ^ r;
    return x[4];
  endfunction
endpackage

// File: rtl/addsub_core.sv
module addsub_core
  import addsub_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              wide,
  output logic [DATA_W-1:0] res,
  output base_flags_t       bf
);
  localparam int HALF_W = DATA_W / 2;
  localparam int LANES  = 2;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] lane_res [LANES];
  logic              lane_c   [LANES];
  logic              lane_v   [LANES];
  logic              lane_n   [LANES];

  assign b_eff = sub ? ~b : b;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = HALF_W << g;
    logic [LW:0] s;
    assign s           = {1'b0, a[LW-1:0]} + {1'b0, b_eff[LW-1:0]} + {{LW{1'b0}}, sub};
    assign lane_res[g] = DATA_W'(s[LW-1:0]);
    assign lane_c[g]   = s[LW];
    assign lane_n[g]   = s[LW-1];
    assign lane_v[g]   = (a[LW-1] == b_eff[LW-1]) && (s[LW-1] != a[LW-1]);
  end

  always_comb begin
    res  = wide ? lane_res[1] : lane_res[0];
    bf.n = wide ? lane_n[1] : lane_n[0];
    bf.c = wide ? lane_c[1] : lane_c[0];
    bf.v = wide ? lane_v[1] : lane_v[0];
    bf.z = (res == '0);
  end
endmodule

// File: rtl/legacy_flag_gen.sv
module legacy_flag_gen
  import addsub_pkg::*;
(
  input  logic [7:0] a_lo,
  input  logic [7:0] b_lo,
  input  logic [7:0] r_lo,
  output logic       pf,
  output logic       af
);
  assign pf = even_parity8(r_lo);
  assign af = nibble_cross(a_lo, b_lo, r_lo);
endmodule

// File: rtl/flags_reg.sv
module flags_reg
  import addsub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_base,
  input  logic              we_legacy,
  input  base_flags_t       bf,
  input  logic              pf,
  input  logic              af,
  output logic [FLAG_W-1:0] flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (we_base) begin
        flags_q[N_BIT] <= bf.n;
        flags_q[Z_BIT] <= bf.z;
        flags_q[C_BIT] <= bf.c;
        flags_q[V_BIT] <= bf.v;
      end
      if (we_legacy) begin
        flags_q[PF_BIT] <= pf;
        flags_q[AF_BIT] <= af;
      end
    end
  end

  a_r10_hold_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_base && !we_legacy) |=> $stable(flags_q));
  a_r9_legacy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_legacy |=> $stable(flags_q[AF_BIT:PF_BIT]));
  a_r11_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    we_base |=> (flags_q[PF_BIT-1:0] == '0));
endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        op_sel,
  input  logic              set_flags,
  input  logic              wide,
  input  logic              legacy_en,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  localparam int HALF_W = DATA_W / 2;

  op_e               op;
  logic              do_sub;
  logic              do_write;
  logic [DATA_W-1:0] core_res;
  base_flags_t       core_bf;
  logic              leg_pf;
  logic              leg_af;
  logic              we_base;
  logic              we_legacy;
  logic [DATA_W-1:0] result_q;

  assign op        = op_e'(op_sel);
  assign do_sub    = is_subtract(op);
  assign do_write  = writes_result(op);
  assign we_base   = set_flags;
  assign we_legacy = set_flags && legacy_en;

  addsub_core #(.DATA_W(DATA_W)) u_core (
    .a    (op_a),
    .b    (op_b),
    .sub  (do_sub),
    .wide (wide),
    .res  (core_res),
    .bf   (core_bf)
  );

  legacy_flag_gen u_legacy (
    .a_lo (op_a[7:0]),
    .b_lo (op_b[7:0]),
    .r_lo (core_res[7:0]),
    .pf   (leg_pf),
    .af   (leg_af)
  );

  flags_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_base   (we_base),
    .we_legacy (we_legacy),
    .bf        (core_bf),
    .pf        (leg_pf),
    .af        (leg_af),
    .flags_q   (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result_q <= '0;
    else if (do_write) result_q <= core_res;
  end

  assign result = result_q;

  a_r3_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CMP) |=> $stable(result));
  a_r1_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && op_sel != OP_CMP) |=> (result[DATA_W-1:HALF_W] == '0));
  a_r4_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_sel != OP_CMP) |=>
      (flags[Z_BIT] == ($past(wide) ? (result == '0) : (result[HALF_W-1:0] == '0))));
  a_r4_sign_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_sel != OP_CMP) |=>
      (flags[N_BIT] == ($past(wide) ? result[DATA_W-1] : result[HALF_W-1])));
endmodule

// File: tb/addsub_flags_unit_bench.sv
module addsub_flags_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  op_sel = '0;
  logic        set_flags = 1'b0, wide = 1'b0, legacy_en = 1'b0;
  logic [63:0] result;
  logic [31:0] flags;

  int total = 0;
  int bad = 0;
  logic [63:0] m_res = '0;
  logic [31:0] m_flags = '0;

  always #4 clk = ~clk;

  addsub_flags_unit u_addsub_flags_unit (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .set_flags(set_flags), .wide(wide), .legacy_en(legacy_en),
    .result(result), .flags(flags)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op,
                       input logic sf, input logic w, input logic le);
    logic [63:0] mask, am, bm, r;
    logic signed [65:0] sa, sb, sr, lim;
    logic is_sub, c, v, n, z, pf, af;
    logic [31:0] ef;
    string rtag, ftag, ltag;
    mask = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    am = a & mask;
    bm = b & mask;
    is_sub = (op == 2'b01) || (op == 2'b10);
    r = (is_sub ? am - bm : am + bm) & mask;
    c = is_sub ? (am >= bm) : (({2'b00, am} + {2'b00, bm}) > {2'b00, mask});
    sa = w ? $signed(a) : $signed(a[31:0]);
    sb = w ? $signed(b) : $signed(b[31:0]);
    sr = is_sub ? sa - sb : sa + sb;
    lim = w ? (66'sd1 <<< 63) : (66'sd1 <<< 31);
    v = (sr >= lim) || (sr < -lim);
    n = w ? r[63] : r[31];
    z = (r == 64'd0);
    pf = ($countones(r[7:0]) % 2) == 0;
    af = is_sub ? (a[3:0] < b[3:0]) : ({1'b0, a[3:0]} + {1'b0, b[3:0]} > 5'd15);
    ef = m_flags;
    if (sf) begin
      ef[31] = n; ef[30] = z; ef[29] = c; ef[28] = v;
      if (le) begin ef[26] = pf; ef[27] = af; end
    end
    op_a = a; op_b = b; op_sel = op; set_flags = sf; wide = w; legacy_en = le;
    @(posedge clk);
    @(negedge clk);
    if (op != 2'b10) m_res = r;
    m_flags = ef;
    rtag = (op == 2'b10) ? "R3 result held on compare" :
           (is_sub ? "R2 subtract result" : "R1 add result");
    ftag = sf ? "" : "R10 ";
    ltag = !sf ? "R10 legacy" : (le ? "R7/R8 legacy" : "R9 legacy hold");
    chk(rtag, result, m_res);
    chk({ftag, "R4 N/Z"}, {62'd0, flags[31:30]}, {62'd0, m_flags[31:30]});
    chk({ftag, "R5 carry"}, {63'd0, flags[29]}, {63'd0, m_flags[29]});
    chk({ftag, "R6 overflow"}, {63'd0, flags[28]}, {63'd0, m_flags[28]});
    chk({ltag, " R7 parity"}, {63'd0, flags[26]}, {63'd0, m_flags[26]});
    chk({ltag, " R8 adjust"}, {63'd0, flags[27]}, {63'd0, m_flags[27]});
    chk("R11 low bits zero", {38'd0, flags[25:0]}, 64'd0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R11 reset result", result, 64'd0);
    chk("R11 reset flags", {32'd0, flags}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 signed overflow at 32-bit boundary
    do_op(64'h0000_0000_7FFF_FFFF, 64'd1, 2'b00, 1, 0, 1);
    // R1 R5 narrow wrap with carry and Z
    do_op(64'hABCD_0000_FFFF_FFFF, 64'd1, 2'b00, 1, 0, 1);
    // R5 64-bit carry out
    do_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 2'b11, 1, 1, 1);
    // R2 equal subtract: Z, C=1
    do_op(64'd1234, 64'd1234, 2'b01, 1, 1, 1);
    // R5 borrow
    do_op(64'd0, 64'd1, 2'b01, 1, 1, 1);
    // R8 nibble carry, R7 parity
    do_op(64'h0F, 64'h01, 2'b00, 1, 1, 1);
    do_op(64'h02, 64'h01, 2'b00, 1, 1, 1);
    // R8 nibble borrow via compare, R3
    do_op(64'h10, 64'h01, 2'b10, 1, 1, 1);
    // R9 legacy off keeps bits 27:26
    do_op(64'h0F, 64'h01, 2'b00, 1, 1, 0);
    do_op(64'h00, 64'h00, 2'b01, 1, 0, 0);
    // R10 no flag update
    do_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'b00, 0, 1, 1);
    do_op(64'h5, 64'h7, 2'b10, 0, 0, 1);
    // R6 64-bit signed overflow on subtract
    do_op(64'h8000_0000_0000_0000, 64'd1, 2'b01, 1, 1, 1);
    for (int i = 0; i < 600; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if ($urandom % 4 == 0) begin ra = ra & 64'hFF; rb = rb & 64'hFF; end
      if ($urandom % 8 == 0) rb = ra;
      do_op(ra, rb, 2'($urandom % 4), ($urandom % 4) != 0, 1'($urandom % 2), 1'($urandom % 2));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule